// File: doc/BRIEF.md
# Data Translation Lookaside Buffer with Fault Reporting

This block translates data addresses for a load/store path. A lookup presents a virtual address, an address-space context, the privilege mode of the access and whether it is a write. Every stored entry is compared against the virtual page number and context in the same cycle. The lowest-numbered valid matching entry decides the outcome: a grant with the physical address, an access-fault trap, a write-protection trap or a miss trap.

Faults leave a status word and the faulting address for the trap handler. Misses leave a tag word that holds the page-aligned address merged with the context, ready for a refill routine. Software fills entries by index, can read each entry's used flag, and clears the status word with a strobe once it has read it.

Control is a five-state machine: `ST_IDLE` (no result), `ST_GRANT` (good hit), `ST_MISS` (no matching entry), `ST_AFLT` (privilege violation) and `ST_PROT` (write to a read-only page). A sampled lookup request moves the machine from any state to the state that names the lookup's outcome. A cycle with no request returns it to `ST_IDLE`. Each non-idle state lasts exactly one cycle unless another request follows.

Top module: `dtlb_lookup`

## Requirements
- R1: An entry hits when it is valid and both its virtual page number (address bits 63:13) and its context equal those of the lookup. When several entries hit, the one with the lowest index supplies the result; an invalid entry never hits.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high. `rsp_trap` is non-zero for that one cycle only, coded 0 none, 1 miss, 2 access fault, 3 write protection.
- R3: A user-mode access (`lk_user`=1) that hits an entry whose attribute bit 2 (privileged) is set reports trap code 2 and sets fault-type bit 0, which is status bit 7. A supervisor access to the same entry is granted.
- R4: A write that hits an entry whose attribute bit 1 (writable) is clear reports trap code 3, and the status fault-type field (bits 8:7) stays zero.
- R5: When an access is both a user access to a privileged page and a write to a read-only page, only the access-fault trap (code 2) is reported.
- R6: On a good hit, `rsp_rd_ok` is 1, `rsp_wr_ok` equals attribute bit 1, `rsp_paddr` is the entry's physical page number followed by address bits 12:0, and the entry's used flag becomes 1.
- R7: When a fault is recorded while status bit 0 is already 1, the status word is first replaced by the value 2 (overflow, bit 1) and the new fault's bits are then merged in.
- R8: A recorded fault ORs into the status word bit 0 (valid), bit 2 (the access was a write), bit 3 (the access was user mode) and the fault type shifted left by 7.
- R9: A fault writes the full 64-bit lookup address to `fault_addr`.
- R10: A miss loads `tag_access` with the lookup address with bits 12:0 cleared, ORed with the context, reports trap code 1, and leaves the status word unchanged.
- R11: Reset and `sw_clr_status` set the status word to zero. When a clear and a fault fall in the same cycle, the status word holds only the new fault. An entry fill clears that entry's used flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request, sampled at the rising edge |
| lk_vaddr | input | 64 | Virtual address of the lookup |
| lk_ctx | input | 13 | Context of the lookup |
| lk_user | input | 1 | 1 for a user-mode access |
| lk_write | input | 1 | 1 for a write access |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_trap | output | 2 | Trap code pulse: 0 none, 1 miss, 2 access fault, 3 protection |
| rsp_rd_ok | output | 1 | Read granted |
| rsp_wr_ok | output | 1 | Write granted |
| rsp_paddr | output | 41 | Translated physical address |
| sw_fill | input | 1 | Write one entry |
| sw_idx | input | 6 | Entry index for a fill |
| sw_valid | input | 1 | Valid bit written by a fill |
| sw_vpn | input | 51 | Virtual page number written by a fill |
| sw_ctx | input | 13 | Context written by a fill |
| sw_attr | input | 2 | Attribute bits 2:1 (2 privileged, 1 writable) |
| sw_ppn | input | 28 | Physical page number written by a fill |
| sw_rd_idx | input | 6 | Entry whose used flag is shown |
| sw_rd_used | output | 1 | Used flag of entry `sw_rd_idx` (combinational) |
| sw_clr_status | input | 1 | Clear the status word |
| fault_status | output | 16 | Fault status word |
| fault_addr | output | 64 | Address of the last fault |
| tag_access | output | 64 | Page address and context of the last miss |

## Verification
Every lookup result, the status word, the fault address, the tag word and the used flag change on the same rising edge that samples `lk_req`. The bench drives each request on a falling edge and reads all of them on the next falling edge. It checks the trap pulse's end one further falling edge later. The used flag is read combinationally after `sw_rd_idx` settles, and the effect of a clear is read on the falling edge after the strobe.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    typedef enum logic [1:0] {
        TRAP_NONE = 2'd0,
        TRAP_MISS = 2'd1,
        TRAP_AFLT = 2'd2,
        TRAP_PROT = 2'd3
    } trap_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GRANT = 3'd1,
        ST_MISS  = 3'd2,
        ST_AFLT  = 3'd3,
        ST_PROT  = 3'd4
    } state_e;

    // status word layout
    localparam int STAT_VALID = 0;
    localparam int STAT_OVF   = 1;
    localparam int STAT_WR    = 2;
    localparam int STAT_USER  = 3;
    localparam int FT_LSB     = 7;
    localparam int FT_W       = 2;

    // fault type codes
    localparam logic [FT_W-1:0] FT_PRIV = 2'b01;
    localparam logic [FT_W-1:0] FT_NONE = 2'b00;

endpackage

// File: rtl/dtlb_entry_array.sv
module dtlb_entry_array #(
    parameter int N     = 64,
    parameter int VPN_W = 51,
    parameter int CTX_W = 13,
    parameter int PPN_W = 28,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [CTX_W-1:0] fill_ctx,
    input  logic [2:1]       fill_attr,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             used_set,
    input  logic [IDX_W-1:0] used_idx,
    input  logic [VPN_W-1:0] cmp_vpn,
    input  logic [CTX_W-1:0] cmp_ctx,
    output logic [N-1:0]     match_vec,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [2:1]       sel_attr,
    output logic [PPN_W-1:0] sel_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used
);

    logic [VPN_W-1:0] vpn_q  [N];
    logic [CTX_W-1:0] ctx_q  [N];
    logic [2:1]       attr_q [N];
    logic [PPN_W-1:0] ppn_q  [N];
    logic [N-1:0]     valid_q;
    logic [N-1:0]     used_q;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic wr_here;
        assign wr_here = fill_en && (fill_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                used_q[g]  <= 1'b0;
            end else if (wr_here) begin
                valid_q[g] <= fill_valid;
                used_q[g]  <= 1'b0;
            end else if (used_set && (used_idx == IDX_W'(g))) begin
                used_q[g]  <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_here) begin
                vpn_q[g]  <= fill_vpn;
                ctx_q[g]  <= fill_ctx;
                attr_q[g] <= fill_attr;
                ppn_q[g]  <= fill_ppn;
            end
        end

        assign match_vec[g] = valid_q[g]
                            && (vpn_q[g] == cmp_vpn)
                            && (ctx_q[g] == cmp_ctx);
    end

    assign sel_attr = attr_q[sel_idx];
    assign sel_ppn  = ppn_q[sel_idx];
    assign rd_used  = used_q[rd_idx];

endmodule

// File: rtl/dtlb_prio_enc.sv
module dtlb_prio_enc #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req_vec;

endmodule

// File: rtl/dtlb_fault_regs.sv
module dtlb_fault_regs
    import dtlb_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PG_BITS = 13,
    parameter int CTX_W   = 13,
    parameter int STAT_W  = 16,
    localparam int VPN_W  = VA_W - PG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rec_fault,
    input  logic              rec_write,
    input  logic              rec_user,
    input  logic [FT_W-1:0]   rec_ftype,
    input  logic              rec_miss,
    input  logic [VA_W-1:0]   rec_addr,
    input  logic [CTX_W-1:0]  rec_ctx,
    output logic [STAT_W-1:0] status,
    output logic [VA_W-1:0]   fault_addr,
    output logic [VA_W-1:0]   tag_access
);

    logic [STAT_W-1:0] base_s;
    logic [STAT_W-1:0] merged_s;
    logic [STAT_W-1:0] new_bits;
    logic [STAT_W-1:0] status_d;
    logic [VPN_W-1:0]  page_num;

    always_comb begin
        base_s = clr ? '0 : status;
        new_bits = '0;
        new_bits[STAT_VALID] = 1'b1;
        new_bits[STAT_WR]    = rec_write;
        new_bits[STAT_USER]  = rec_user;
        new_bits[FT_LSB +: FT_W] = rec_ftype;
        merged_s = base_s[STAT_VALID] ? STAT_W'(2) : base_s;
        status_d = rec_fault ? (merged_s | new_bits) : base_s;
    end

    assign page_num = rec_addr[VA_W-1:PG_BITS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status     <= '0;
            fault_addr <= '0;
            tag_access <= '0;
        end else begin
            status <= status_d;
            if (rec_fault) fault_addr <= rec_addr;
            if (rec_miss)  tag_access <= {page_num, PG_BITS'(0)} | VA_W'(rec_ctx);
        end
    end

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
    import dtlb_pkg::*;
#(
    parameter int N       = 64,
    parameter int VA_W    = 64,
    parameter int PG_BITS = 13,
    parameter int CTX_W   = 13,
    parameter int PPN_W   = 28,
    parameter int STAT_W  = 16,
    localparam int IDX_W  = $clog2(N),
    localparam int VPN_W  = VA_W - PG_BITS,
    localparam int PA_W   = PPN_W + PG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic              lk_user,
    input  logic              lk_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_trap,
    output logic              rsp_rd_ok,
    output logic              rsp_wr_ok,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              sw_fill,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_valid,
    input  logic [VPN_W-1:0]  sw_vpn,
    input  logic [CTX_W-1:0]  sw_ctx,
    input  logic [2:1]        sw_attr,
    input  logic [PPN_W-1:0]  sw_ppn,
    input  logic [IDX_W-1:0]  sw_rd_idx,
    output logic              sw_rd_used,
    input  logic              sw_clr_status,
    output logic [STAT_W-1:0] fault_status,
    output logic [VA_W-1:0]   fault_addr,
    output logic [VA_W-1:0]   tag_access
);

    state_e state_q, state_d, cls;

    logic [N-1:0]     match_vec;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic [2:1]       hit_attr;
    logic [PPN_W-1:0] hit_ppn;
    logic [PA_W-1:0]  paddr_q;
    logic             wr_ok_q;
    logic             grant_now;
    logic             fault_now;
    logic             miss_now;
    trap_e            trap_out;

    dtlb_entry_array #(
        .N(N), .VPN_W(VPN_W), .CTX_W(CTX_W), .PPN_W(PPN_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (sw_fill),
        .fill_idx   (sw_idx),
        .fill_valid (sw_valid),
        .fill_vpn   (sw_vpn),
        .fill_ctx   (sw_ctx),
        .fill_attr  (sw_attr),
        .fill_ppn   (sw_ppn),
        .used_set   (grant_now),
        .used_idx   (hit_idx),
        .cmp_vpn    (lk_vaddr[VA_W-1:PG_BITS]),
        .cmp_ctx    (lk_ctx),
        .match_vec  (match_vec),
        .sel_idx    (hit_idx),
        .sel_attr   (hit_attr),
        .sel_ppn    (hit_ppn),
        .rd_idx     (sw_rd_idx),
        .rd_used    (sw_rd_used)
    );

    dtlb_prio_enc #(.N(N)) u_prio (
        .req_vec (match_vec),
        .any     (hit_any),
        .idx     (hit_idx)
    );

    // outcome of the lookup presented this cycle; privilege before write
    always_comb begin
        if (!hit_any)                     cls = ST_MISS;
        else if (hit_attr[2] && lk_user)  cls = ST_AFLT;
        else if (!hit_attr[1] && lk_write) cls = ST_PROT;
        else                              cls = ST_GRANT;
    end

    assign grant_now = lk_req && (cls == ST_GRANT);
    assign fault_now = lk_req && ((cls == ST_AFLT) || (cls == ST_PROT));
    assign miss_now  = lk_req && (cls == ST_MISS);

    dtlb_fault_regs #(
        .VA_W(VA_W), .PG_BITS(PG_BITS), .CTX_W(CTX_W), .STAT_W(STAT_W)
    ) u_fregs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sw_clr_status),
        .rec_fault  (fault_now),
        .rec_write  (lk_write),
        .rec_user   (lk_user),
        .rec_ftype  ((cls == ST_AFLT) ? FT_PRIV : FT_NONE),
        .rec_miss   (miss_now),
        .rec_addr   (lk_vaddr),
        .rec_ctx    (lk_ctx),
        .status     (fault_status),
        .fault_addr (fault_addr),
        .tag_access (tag_access)
    );

    // next state
    always_comb begin
        state_d = lk_req ? cls : ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // grant data captured alongside the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            wr_ok_q <= 1'b0;
        end else if (lk_req) begin
            paddr_q <= {hit_ppn, lk_vaddr[PG_BITS-1:0]};
            wr_ok_q <= hit_attr[1];
        end
    end

    // outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_rd_ok = 1'b0;
        rsp_wr_ok = 1'b0;
        rsp_paddr = '0;
        trap_out  = TRAP_NONE;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_GRANT: begin
                rsp_valid = 1'b1;
                rsp_rd_ok = 1'b1;
                rsp_wr_ok = wr_ok_q;
                rsp_paddr = paddr_q;
            end
            ST_MISS: begin
                rsp_valid = 1'b1;
                trap_out  = TRAP_MISS;
            end
            ST_AFLT: begin
                rsp_valid = 1'b1;
                trap_out  = TRAP_AFLT;
            end
            ST_PROT: begin
                rsp_valid = 1'b1;
                trap_out  = TRAP_PROT;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end

    assign rsp_trap = trap_out;

endmodule

// File: rtl/dtlb_lookup_chk.sv
module dtlb_lookup_chk
    import dtlb_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int PG_BITS = 13,
    parameter int CTX_W   = 13,
    parameter int STAT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [CTX_W-1:0]  lk_ctx,
    input logic              rsp_valid,
    input logic [1:0]        rsp_trap,
    input logic              rsp_rd_ok,
    input logic              rsp_wr_ok,
    input logic              sw_clr_status,
    input logic [STAT_W-1:0] fault_status,
    input logic [VA_W-1:0]   fault_addr,
    input logic [VA_W-1:0]   tag_access
);

    // R2
    req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_valid && rsp_trap == 2'd0));

    // R6
    grant_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_ok |-> (rsp_rd_ok && rsp_trap == 2'd0));

    // R3
    priv_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap == 2'd2) |-> (fault_status[STAT_VALID] && fault_status[STAT_USER]
                                && fault_status[FT_LSB]));

    // R4
    prot_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap == 2'd3) |-> (fault_status[STAT_VALID] && fault_status[STAT_WR]
                                && fault_status[FT_LSB +: FT_W] == '0));

    // R9
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap[1] |-> (fault_addr == $past(lk_vaddr)));

    // R10
    miss_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap == 2'd1) |-> (tag_access ==
            ({$past(lk_vaddr[VA_W-1:PG_BITS]), PG_BITS'(0)} | VA_W'($past(lk_ctx)))));

    // R10
    miss_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap == 2'd1 && !$past(sw_clr_status)) |-> $stable(fault_status));

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_status && !lk_req) |=> (fault_status == '0));

endmodule

bind dtlb_lookup dtlb_lookup_chk #(
    .VA_W(VA_W), .PG_BITS(PG_BITS), .CTX_W(CTX_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/tb_dtlb_lookup.sv
`timescale 1ns/1ps
module tb_dtlb_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [63:0] lk_vaddr = '0;
    logic [12:0] lk_ctx = '0;
    logic        lk_user = 1'b0;
    logic        lk_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_trap;
    logic        rsp_rd_ok;
    logic        rsp_wr_ok;
    logic [40:0] rsp_paddr;
    logic        sw_fill = 1'b0;
    logic [5:0]  sw_idx = '0;
    logic        sw_valid = 1'b0;
    logic [50:0] sw_vpn = '0;
    logic [12:0] sw_ctx = '0;
    logic [2:1]  sw_attr = '0;
    logic [27:0] sw_ppn = '0;
    logic [5:0]  sw_rd_idx = '0;
    logic        sw_rd_used;
    logic        sw_clr_status = 1'b0;
    logic [15:0] fault_status;
    logic [63:0] fault_addr;
    logic [63:0] tag_access;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dtlb_lookup dut (.*);

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic fill(input int idx, input bit v, input logic [50:0] vpn,
                        input logic [12:0] ctx, input logic [2:1] attr,
                        input logic [27:0] ppn);
        @(negedge clk);
        sw_fill = 1'b1; sw_idx = 6'(idx); sw_valid = v;
        sw_vpn = vpn; sw_ctx = ctx; sw_attr = attr; sw_ppn = ppn;
        @(negedge clk);
        sw_fill = 1'b0;
    endtask

    // drive one request; on return the result cycle is on the outputs
    task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                          input bit user, input bit wr);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_ctx = ctx; lk_user = user; lk_write = wr;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    function automatic logic used_of(input int idx);
        return 1'b0;
    endfunction

    task automatic peek_used(input int idx, output logic u);
        sw_rd_idx = 6'(idx);
        #0.5;
        u = sw_rd_used;
    endtask

    task automatic clear_status();
        @(negedge clk);
        sw_clr_status = 1'b1;
        @(negedge clk);
        sw_clr_status = 1'b0;
    endtask

    localparam logic [50:0] VPN_A = 51'h1_2345_6789;
    localparam logic [50:0] VPN_B = 51'h0_00AB_CDEF;
    localparam logic [50:0] VPN_C = 51'h7_0000_0042;

    task automatic t_reset();
        logic u;
        chk("R2", "valid after reset", 64'(rsp_valid), 64'd0);
        chk("R2", "trap after reset", 64'(rsp_trap), 64'd0);
        chk("R11", "status after reset", 64'(fault_status), 64'd0);
        peek_used(5, u);
        chk("R11", "used after reset", 64'(u), 64'd0);
    endtask

    task automatic t_hit();
        logic [63:0] va;
        logic u;
        va = {VPN_A, 13'h0ABC};
        fill(5, 1'b1, VPN_A, 13'd3, 2'b01, 28'h123_4567);
        lookup(va, 13'd3, 1'b1, 1'b0);
        chk("R2", "hit valid", 64'(rsp_valid), 64'd1);
        chk("R1", "hit trap", 64'(rsp_trap), 64'd0);
        chk("R6", "hit read", 64'(rsp_rd_ok), 64'd1);
        chk("R6", "hit write", 64'(rsp_wr_ok), 64'd1);
        chk("R6", "hit paddr", 64'(rsp_paddr), 64'({28'h123_4567, 13'h0ABC}));
        peek_used(5, u);
        chk("R6", "used set", 64'(u), 64'd1);
        @(negedge clk);
        chk("R2", "valid drops", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_ctx_miss();
        logic [63:0] va;
        va = {VPN_A, 13'h1FFF};
        lookup(va, 13'd4, 1'b0, 1'b1);
        chk("R1", "context mismatch trap", 64'(rsp_trap), 64'd1);
        chk("R10", "miss tag", tag_access, {VPN_A, 13'd4});
        chk("R10", "miss status", 64'(fault_status), 64'd0);
        chk("R10", "miss no grant", 64'(rsp_rd_ok), 64'd0);
        @(negedge clk);
        chk("R2", "miss pulse ends", 64'(rsp_trap), 64'd0);
    endtask

    task automatic t_multi();
        fill(2, 1'b0, VPN_B, 13'd1, 2'b01, 28'h000_0002);
        fill(9, 1'b1, VPN_B, 13'd1, 2'b01, 28'h000_0009);
        fill(7, 1'b1, VPN_B, 13'd1, 2'b01, 28'h000_0007);
        lookup({VPN_B, 13'h0010}, 13'd1, 1'b0, 1'b0);
        chk("R1", "lowest index wins", 64'(rsp_paddr), 64'({28'h000_0007, 13'h0010}));
    endtask

    task automatic t_readonly();
        fill(11, 1'b1, VPN_C, 13'd0, 2'b00, 28'h0AA_0000);
        lookup({VPN_C, 13'h0001}, 13'd0, 1'b0, 1'b0);
        chk("R6", "readonly read", 64'(rsp_rd_ok), 64'd1);
        chk("R6", "readonly no write", 64'(rsp_wr_ok), 64'd0);
    endtask

    task automatic t_priv();
        logic [63:0] va;
        logic u;
        va = {VPN_C + 51'd1, 13'h0123};
        fill(12, 1'b1, VPN_C + 51'd1, 13'd2, 2'b11, 28'h0BB_0000);
        lookup(va, 13'd2, 1'b1, 1'b0);
        chk("R3", "priv trap", 64'(rsp_trap), 64'd2);
        chk("R3", "priv no grant", 64'(rsp_rd_ok), 64'd0);
        chk("R8", "priv status", 64'(fault_status), 64'h0089);
        chk("R9", "priv fault addr", fault_addr, va);
        peek_used(12, u);
        chk("R3", "fault leaves used", 64'(u), 64'd0);
        lookup(va, 13'd2, 1'b0, 1'b1);
        chk("R3", "supervisor grant", 64'(rsp_wr_ok), 64'd1);
    endtask

    task automatic t_clear();
        clear_status();
        chk("R11", "clear", 64'(fault_status), 64'd0);
    endtask

    task automatic t_prot();
        logic [63:0] va;
        va = {VPN_C, 13'h0777};
        lookup(va, 13'd0, 1'b0, 1'b1);
        chk("R4", "prot trap", 64'(rsp_trap), 64'd3);
        chk("R4", "prot status", 64'(fault_status), 64'h0005);
        chk("R9", "prot fault addr", fault_addr, va);
    endtask

    task automatic t_overflow();
        lookup({VPN_C + 51'd1, 13'h0000}, 13'd2, 1'b1, 1'b0);
        chk("R7", "overflow status", 64'(fault_status), 64'h008B);
    endtask

    task automatic t_prio();
        clear_status();
        fill(13, 1'b1, VPN_C + 51'd2, 13'd5, 2'b10, 28'h0CC_0000);
        lookup({VPN_C + 51'd2, 13'h0004}, 13'd5, 1'b1, 1'b1);
        chk("R5", "priv before prot", 64'(rsp_trap), 64'd2);
        chk("R5", "combined status", 64'(fault_status), 64'h008D);
    endtask

    task automatic t_clear_and_fault();
        @(negedge clk);
        sw_clr_status = 1'b1;
        lk_req = 1'b1; lk_vaddr = {VPN_C, 13'h0002}; lk_ctx = 13'd0;
        lk_user = 1'b0; lk_write = 1'b1;
        @(negedge clk);
        sw_clr_status = 1'b0; lk_req = 1'b0;
        chk("R11", "clear with fault", 64'(fault_status), 64'h0005);
    endtask

    task automatic t_refill();
        logic u;
        fill(5, 1'b1, VPN_A, 13'd3, 2'b01, 28'h123_4567);
        peek_used(5, u);
        chk("R11", "fill clears used", 64'(u), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_ctx_miss();
        t_multi();
        t_readonly();
        t_priv();
        t_clear();
        t_prot();
        t_overflow();
        t_prio();
        t_clear_and_fault();
        t_refill();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule